// File: doc/BRIEF.md
# Array Microcode Sequencer

This block drives a bit-serial processing array. A supervising processor stores short task descriptors in sixteen slots. Each descriptor holds a microcode entry point, a loop re-entry point, a loop count, a base bit address and two branch targets. When the sequencer receives a start request with a slot number, it copies that descriptor into working registers. It then walks a built-in microprogram. On every run cycle it emits one 50-bit array control word.

Sequencing is linear unless the current microword says otherwise. A loop microword tests the loop counter. If the counter is nonzero, the sequencer decrements it and returns to the re-entry point. The counter is also added to the bit address sent to the array, so one loop body can sweep a field of consecutive bits. A branch microword compares the array's responder class with a reference carried in the microword, then jumps to one of the descriptor's two targets. An end microword finishes the task: the sequencer raises an interrupt and holds it until the next start request arrives.

Top module: `uc_sequencer`

## Requirements
- R1: While reset is asserted, and on the cycle after it is released, `arr_valid` and `task_irq` are 0.
- R2: A `start` pulse sampled while idle or waiting moves the sequencer to a one-cycle load state. In that state `arr_valid` and `task_irq` are 0. The first control word, taken from the slot's entry point, is issued in the following cycle.
- R3: Opcode NEXT (0) moves the microcode address to address + 1 on the next cycle.
- R4: Opcode LOOP (1) with a nonzero counter decrements the counter and jumps to the slot's loop re-entry point. With a zero counter it falls through to address + 1 and leaves the counter unchanged.
- R5: The bit address equals base + (low 4 bits of the microcode address) + counter, taken modulo 1024.
- R6: Opcode BRANCH (2) compares the responder class (0 = none, 1 = one, 2 = many, 3 is treated as many) with the 2-bit reference in the microword. On a match it jumps to target A; otherwise it jumps to target B.
- R7: Opcode END (3) issues its word. From the next cycle, `task_irq` is 1 and `arr_valid` is 0, and both hold until a `start` is sampled.
- R8: `start` is ignored during the load and run states. The running task continues unchanged.
- R9: Slot writes are stored per slot. A task uses the slot contents that were present at its load cycle. A write to the running slot takes effect only on that slot's next start.
- R10: `arr_word` is {bit address[9:0], five copies of {2'b10, microcode address[5:0]}}. It is 0 when `arr_valid` is 0.
- R11: The built-in program is as follows: LOOP at 3 and 20; BRANCH with reference 1 at 7; BRANCH with reference 0 at 12; END at 9, 15, 22 and 63; NEXT at every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_we | input | 1 | Write strobe for one task slot |
| blk_wr_idx | input | 4 | Slot number being written |
| blk_start | input | 6 | Microcode entry point |
| blk_loop | input | 6 | Loop re-entry point |
| blk_count | input | 8 | Initial loop count |
| blk_base | input | 10 | Base bit address |
| blk_tgt_a | input | 6 | Branch target on a responder match |
| blk_tgt_b | input | 6 | Branch target on a mismatch |
| start | input | 1 | Request to run a slot |
| start_idx | input | 4 | Slot to run |
| resp_class | input | 2 | Responder class from the array |
| arr_valid | output | 1 | Control word is being issued |
| arr_word | output | 50 | Array control word |
| task_irq | output | 1 | Task finished; next slot requested |

## Verification
The assertions check properties that hold on every cycle. Reset leaves both outputs quiet. An end word is always followed by the interrupt. The interrupt holds until a start arrives, and a start from the waiting state passes through exactly one load cycle. A run continues without a gap until an end word. The loop counter never rises within a run. Only the bench scenarios can show that the word sequence is correct. That covers the loop counts, the chosen branch targets, the index-offset bit addresses including wrap-around, and the isolation of a running task from slot rewrites. The bench compares each issued word against its own model of the program.

// File: rtl/uc_sequencer.sv
module uc_sequencer #(
  parameter int UA_W     = 6,
  parameter int CNT_W    = 8,
  parameter int BA_W     = 10,
  parameter int OFF_W    = 4,
  parameter int OPS_REPS = 5,
  parameter int NBLK     = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  blk_we,
  input  logic [$clog2(NBLK)-1:0]               blk_wr_idx,
  input  logic [UA_W-1:0]                       blk_start,
  input  logic [UA_W-1:0]                       blk_loop,
  input  logic [CNT_W-1:0]                      blk_count,
  input  logic [BA_W-1:0]                       blk_base,
  input  logic [UA_W-1:0]                       blk_tgt_a,
  input  logic [UA_W-1:0]                       blk_tgt_b,
  input  logic                                  start,
  input  logic [$clog2(NBLK)-1:0]               start_idx,
  input  logic [1:0]                            resp_class,
  output logic                                  arr_valid,
  output logic [BA_W+OPS_REPS*(UA_W+2)-1:0]     arr_word,
  output logic                                  task_irq
);
  localparam int IDX_W  = $clog2(NBLK);
  localparam int OPS_W  = OPS_REPS * (UA_W + 2);
  localparam int WORD_W = BA_W + OPS_W;

  localparam logic [1:0] OP_NEXT = 2'd0;
  localparam logic [1:0] OP_LOOP = 2'd1;
  localparam logic [1:0] OP_BR   = 2'd2;
  localparam logic [1:0] OP_END  = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_WAIT} state_t;

  function automatic logic [3:0] rom_ctl(input logic [UA_W-1:0] a);
    case (a)
      UA_W'(3):  rom_ctl = {OP_LOOP, 2'd0};
      UA_W'(7):  rom_ctl = {OP_BR,   2'd1};
      UA_W'(9):  rom_ctl = {OP_END,  2'd0};
      UA_W'(12): rom_ctl = {OP_BR,   2'd0};
      UA_W'(15): rom_ctl = {OP_END,  2'd0};
      UA_W'(20): rom_ctl = {OP_LOOP, 2'd0};
      UA_W'(22): rom_ctl = {OP_END,  2'd0};
      default:   rom_ctl = (a == '1) ? {OP_END, 2'd0} : {OP_NEXT, 2'd0};
    endcase
  endfunction

  logic [UA_W-1:0]  m_start [NBLK];
  logic [UA_W-1:0]  m_loop  [NBLK];
  logic [CNT_W-1:0] m_count [NBLK];
  logic [BA_W-1:0]  m_base  [NBLK];
  logic [UA_W-1:0]  m_tgt_a [NBLK];
  logic [UA_W-1:0]  m_tgt_b [NBLK];

  always_ff @(posedge clk) begin
    if (blk_we) begin
      m_start[blk_wr_idx] <= blk_start;
      m_loop[blk_wr_idx]  <= blk_loop;
      m_count[blk_wr_idx] <= blk_count;
      m_base[blk_wr_idx]  <= blk_base;
      m_tgt_a[blk_wr_idx] <= blk_tgt_a;
      m_tgt_b[blk_wr_idx] <= blk_tgt_b;
    end
  end

  state_t           state;
  logic [IDX_W-1:0] sel_q;
  logic [UA_W-1:0]  pc, loop_q, ta_q, tb_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BA_W-1:0]  base_q;

  logic [1:0] op, ref_cls, cls;
  logic       hit;
  logic [BA_W-1:0] bit_addr;

  assign {op, ref_cls} = rom_ctl(pc);
  assign cls      = (resp_class == 2'd3) ? 2'd2 : resp_class;
  assign hit      = (cls == ref_cls);
  assign bit_addr = base_q + BA_W'(pc[OFF_W-1:0]) + BA_W'(cnt_q);

  assign arr_valid = (state == S_RUN);
  assign task_irq  = (state == S_WAIT);
  assign arr_word  = arr_valid ? {bit_addr, {OPS_REPS{2'b10, pc}}} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sel_q  <= '0;
      pc     <= '0;
      cnt_q  <= '0;
      base_q <= '0;
      loop_q <= '0;
      ta_q   <= '0;
      tb_q   <= '0;
    end else begin
      case (state)
        S_IDLE, S_WAIT: begin
          if (start) begin
            sel_q <= start_idx;
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          pc     <= m_start[sel_q];
          loop_q <= m_loop[sel_q];
          cnt_q  <= m_count[sel_q];
          base_q <= m_base[sel_q];
          ta_q   <= m_tgt_a[sel_q];
          tb_q   <= m_tgt_b[sel_q];
          state  <= S_RUN;
        end
        S_RUN: begin
          case (op)
            OP_LOOP: begin
              if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
                pc    <= loop_q;
              end else begin
                pc <= pc + UA_W'(1);
              end
            end
            OP_BR:   pc <= hit ? ta_q : tb_q;
            OP_END:  state <= S_WAIT;
            default: pc <= pc + UA_W'(1);
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uc_sequencer_chk.sv
module uc_sequencer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             arr_valid,
  input logic             task_irq,
  input logic [1:0]       op,
  input logic [CNT_W-1:0] cnt
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!arr_valid && !task_irq));

  a_r7_end_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && op == 2'd3) |=> (task_irq && !arr_valid));

  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (task_irq && !start) |=> task_irq);

  a_r2_one_load_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (task_irq && start) |=> (!task_irq && !arr_valid) ##1 arr_valid);

  a_r8_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && op != 2'd3) |=> arr_valid);

  a_r4_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && $past(arr_valid)) |-> (cnt <= $past(cnt)));
endmodule

bind uc_sequencer uc_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .arr_valid(arr_valid),
  .task_irq(task_irq), .op(op), .cnt(cnt_q)
);

// File: tb/uc_sequencer_bench.sv
`timescale 1ns/1ps
module uc_sequencer_bench;
  logic clk = 0, rst_n = 0;
  logic blk_we = 0;
  logic [3:0] blk_wr_idx = 0, start_idx = 0;
  logic [5:0] blk_start = 0, blk_loop = 0, blk_tgt_a = 0, blk_tgt_b = 0;
  logic [7:0] blk_count = 0;
  logic [9:0] blk_base = 0;
  logic start = 0;
  logic [1:0] resp_class = 0;
  logic arr_valid, task_irq;
  logic [49:0] arr_word;

  int n_chk = 0, n_fail = 0;

  logic [5:0] b_start [16], b_loop [16], b_ta [16], b_tb [16];
  logic [7:0] b_cnt [16];
  logic [9:0] b_base [16];

  always #5 clk = ~clk;

  uc_sequencer u_uc_sequencer (
    .clk(clk), .rst_n(rst_n), .blk_we(blk_we), .blk_wr_idx(blk_wr_idx),
    .blk_start(blk_start), .blk_loop(blk_loop), .blk_count(blk_count),
    .blk_base(blk_base), .blk_tgt_a(blk_tgt_a), .blk_tgt_b(blk_tgt_b),
    .start(start), .start_idx(start_idx), .resp_class(resp_class),
    .arr_valid(arr_valid), .arr_word(arr_word), .task_irq(task_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] prog(input logic [5:0] a);
    case (a)
      6'd3, 6'd20: prog = 4'b0100;
      6'd7:        prog = 4'b1001;
      6'd12:       prog = 4'b1000;
      6'd9, 6'd15, 6'd22, 6'd63: prog = 4'b1100;
      default:     prog = 4'b0000;
    endcase
  endfunction

  task automatic drive_blk(input int i, input logic [5:0] s, input logic [5:0] l,
                           input logic [7:0] c, input logic [9:0] b,
                           input logic [5:0] ta, input logic [5:0] tb);
    blk_we = 1; blk_wr_idx = 4'(i); blk_start = s; blk_loop = l;
    blk_count = c; blk_base = b; blk_tgt_a = ta; blk_tgt_b = tb;
    b_start[i] = s; b_loop[i] = l; b_cnt[i] = c; b_base[i] = b; b_ta[i] = ta; b_tb[i] = tb;
  endtask

  task automatic wr_blk(input int i, input logic [5:0] s, input logic [5:0] l,
                        input logic [7:0] c, input logic [9:0] b,
                        input logic [5:0] ta, input logic [5:0] tb);
    @(negedge clk);
    drive_blk(i, s, l, c, b, ta, tb);
    @(negedge clk);
    blk_we = 0;
  endtask

  task automatic run_task(input int idx, input logic [1:0] rc, input bit disturb, input string tag);
    logic [5:0] pc = b_start[idx];
    logic [5:0] lp = b_loop[idx], ta = b_ta[idx], tb = b_tb[idx];
    logic [7:0] cnt = b_cnt[idx];
    logic [9:0] base = b_base[idx];
    logic [9:0] ea;
    logic [3:0] pr;
    logic [1:0] cls;
    bit done = 0;
    int n = 0;
    resp_class = rc;
    @(negedge clk);
    start = 1; start_idx = 4'(idx);
    @(negedge clk);
    start = 0;
    chk({"R2 load cycle quiet ", tag}, {62'd0, arr_valid, task_irq}, 64'd0);
    while (!done && n < 300) begin
      @(negedge clk);
      start = 0; blk_we = 0;
      ea = base + 10'(pc[3:0]) + 10'(cnt);
      chk({"R3/R10 valid ", tag}, 64'(arr_valid), 64'd1);
      chk({"R5/R10/R11 word ", tag}, 64'(arr_word), 64'({ea, {5{2'b10, pc}}}));
      pr = prog(pc);
      cls = (rc == 2'd3) ? 2'd2 : rc;
      case (pr[3:2])
        2'd1: if (cnt != 0) begin cnt--; pc = lp; end else pc++;
        2'd2: pc = (cls == pr[1:0]) ? ta : tb;
        2'd3: done = 1;
        default: pc++;
      endcase
      if (disturb && n == 2) begin
        start = 1; start_idx = 4'(idx ^ 1);
        drive_blk(idx, 6'd20, 6'd0, 8'd0, 10'd7, 6'd0, 6'd0);
      end
      n++;
    end
    if (!done) chk({"R7 task never ended ", tag}, 64'd0, 64'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({"R7 waiting irq ", tag}, {62'd0, arr_valid, task_irq}, 64'd1);
    end
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", 64'(arr_valid), 64'd0);
    chk("R1 irq in reset", 64'(task_irq), 64'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 quiet after reset", {62'd0, arr_valid, task_irq}, 64'd0);
    chk("R10 word zero when idle", 64'(arr_word), 64'd0);
  endtask

  task automatic t_loop_then_match();  run_task(0, 2'd1, 0, "R4 R6 loop then match"); endtask
  task automatic t_wrap_many();        run_task(1, 2'd3, 0, "R5 R6 wrap class3"); endtask
  task automatic t_index_sweep();      run_task(2, 2'd0, 0, "R4 R5 index sweep"); endtask
  task automatic t_match_none();       run_task(3, 2'd0, 0, "R6 none match"); endtask
  task automatic t_ignore_and_rewrite(); run_task(0, 2'd2, 1, "R8 R9 running isolated"); endtask
  task automatic t_rerun_rewritten();  run_task(0, 2'd0, 0, "R9 rewritten slot"); endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    wr_blk(0, 6'd0,  6'd1,  8'd2, 10'd100,  6'd8,  6'd13);
    wr_blk(1, 6'd5,  6'd5,  8'd0, 10'd1020, 6'd9,  6'd13);
    wr_blk(2, 6'd16, 6'd17, 8'd3, 10'd0,    6'd0,  6'd0);
    wr_blk(3, 6'd10, 6'd10, 8'd5, 10'd500,  6'd15, 6'd0);
    t_reset();
    t_loop_then_match();
    t_wrap_many();
    t_index_sweep();
    t_match_none();
    t_ignore_and_rewrite();
    t_rerun_rewritten();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule